// File: doc/BRIEF.md
# Dual-Mode SPI Serial Clock Divider

This block derives the serial clock of an SPI master from its module clock. A 13-bit control word carries two divider fields and a select bit, so one of two division laws can be applied: a linear even divider for fine steps, or a power-of-two divider for a very wide range. The shift engine holds `run_en` high for the whole transfer and uses the two one-cycle strobes to launch and capture bits on the leading and trailing edges of the serial clock.

The control word is captured only while `run_en` is low. Changes made during a transfer therefore take effect only at the next transfer, and no shortened clock phase can appear. While idle, the serial clock rests low. Software picks the field values from the target rate. For the linear law to reach a given serial rate, the module clock must run at least twice that rate. Polarity and phase handling belong to the shift engine.

Top module: `spi_dual_clkdiv`

## Requirements
- R1: After reset, `sclk`, `lead_stb` and `trail_stb` are all 0.
- R2: Linear law. With `div_ctrl[12]`=1 and N=`div_ctrl[7:0]`, each phase of `sclk` lasts N+1 module-clock cycles, so the period is 2*(N+1) cycles.
- R3: Power-of-two law. With `div_ctrl[12]`=0 and M=`div_ctrl[11:8]`, the `sclk` period is 2^M cycles for M>=1. M=0 is treated like M=1: a strobe fires every cycle and `sclk` toggles every cycle.
- R4: `div_ctrl[12]` selects the law. The field that is not selected has no effect on `sclk` or the strobes.
- R5: While `run_en` is low, `sclk` is 0 and no strobe fires. On the clock edge that samples `run_en` low, `sclk` returns to 0.
- R6: `div_ctrl` is captured only on edges where `run_en` is low. Changing it while `run_en` stays high does not alter the running clock.
- R7: `lead_stb` is high for exactly the one cycle in which `sclk` has just risen. `trail_stb` is high for exactly the one cycle in which `sclk` has just fallen. The two strobes are never high together.
- R8: Let H be the phase length. If the first edge that samples `run_en` high is counted as edge 1, then after edge t `sclk` equals floor(t/H) mod 2. The first rise comes after edge H, and the duty cycle is 50%.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | High for the duration of a transfer |
| div_ctrl | input | 13 | [7:0] linear field, [11:8] power field, [12] law select (1 = linear) |
| sclk | output | 1 | Serial clock level, idles at 0 |
| lead_stb | output | 1 | One-cycle pulse as `sclk` rises |
| trail_stb | output | 1 | One-cycle pulse as `sclk` falls |

## Verification
All three outputs are registered. The bench therefore samples them on the falling edge that follows each rising edge, and it counts rising edges from the first one that sees `run_en` high. After t such edges, the expected level is floor(t/H) mod 2, and a strobe is expected exactly when t is a nonzero multiple of H. The bench checks this value after every edge of each trial, not only at the transitions. A stopped transfer must return `sclk` to 0 one edge after `run_en` drops, and the bench checks that at the first falling edge afterwards.

// File: rtl/spi_clkdiv_pkg.sv
package spi_clkdiv_pkg;
  localparam int LIN_W_DEF = 8;
  localparam int POW_W_DEF = 4;

  typedef enum logic {
    LAW_POW2   = 1'b0,
    LAW_LINEAR = 1'b1
  } div_law_e;

  function automatic int cnt_width(input int lin_w, input int pow_w);
    int p;
    p = (1 << pow_w) - 1;
    return (p > lin_w + 1) ? p : lin_w + 1;
  endfunction
endpackage

// File: rtl/clkdiv_half_decode.sv
module clkdiv_half_decode #(
  parameter int LIN_W = 8,
  parameter int POW_W = 4,
  parameter int CNT_W = 15
) (
  input  logic [LIN_W+POW_W:0] ctrl,
  output logic [CNT_W-1:0]     half
);
  import spi_clkdiv_pkg::*;

  logic [LIN_W-1:0] lin_f;
  logic [POW_W-1:0] pow_f;
  div_law_e         law;
  logic [POW_W-1:0] shamt;
  logic [CNT_W-1:0] half_lin;
  logic [CNT_W-1:0] half_pow;

  assign lin_f = ctrl[LIN_W-1:0];
  assign pow_f = ctrl[LIN_W+POW_W-1:LIN_W];
  assign law   = div_law_e'(ctrl[LIN_W+POW_W]);

  // a phase of one cycle is the shortest, so exponents 0 and 1 coincide
  assign shamt    = (pow_f == '0) ? '0 : pow_f - 1'b1;
  assign half_pow = {{(CNT_W-1){1'b0}}, 1'b1} << shamt;
  assign half_lin = CNT_W'(lin_f) + CNT_W'(1);

  always_comb begin
    unique case (law)
      LAW_LINEAR: half = half_lin;
      default:    half = half_pow;
    endcase
  end
endmodule

// File: rtl/clkdiv_phase_cnt.sv
module clkdiv_phase_cnt #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [CNT_W-1:0] half_in,
  output logic [CNT_W-1:0] half_q,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign last = half_q - CNT_W'(1);
  assign tick = run_en && (cnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= CNT_W'(1);
      cnt_q  <= '0;
    end else if (!run_en) begin
      half_q <= half_in;
      cnt_q  <= '0;
    end else if (tick) begin
      cnt_q  <= '0;
    end else begin
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/clkdiv_edge_gen.sv
module clkdiv_edge_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic tick,
  output logic sclk,
  output logic lead_stb,
  output logic trail_stb
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk      <= 1'b0;
      lead_stb  <= 1'b0;
      trail_stb <= 1'b0;
    end else if (!run_en) begin
      sclk      <= 1'b0;
      lead_stb  <= 1'b0;
      trail_stb <= 1'b0;
    end else begin
      lead_stb  <= tick && !sclk;
      trail_stb <= tick && sclk;
      if (tick) sclk <= !sclk;
    end
  end
endmodule

// File: rtl/spi_dual_clkdiv.sv
module spi_dual_clkdiv #(
  parameter int LIN_W = spi_clkdiv_pkg::LIN_W_DEF,
  parameter int POW_W = spi_clkdiv_pkg::POW_W_DEF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run_en,
  input  logic [LIN_W+POW_W:0] div_ctrl,
  output logic                 sclk,
  output logic                 lead_stb,
  output logic                 trail_stb
);
  localparam int CNT_W = spi_clkdiv_pkg::cnt_width(LIN_W, POW_W);

  logic [CNT_W-1:0] half_next;
  logic [CNT_W-1:0] half_q;
  logic             tick;

  clkdiv_half_decode #(.LIN_W(LIN_W), .POW_W(POW_W), .CNT_W(CNT_W)) u_dec (
    .ctrl (div_ctrl),
    .half (half_next)
  );

  clkdiv_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_en  (run_en),
    .half_in (half_next),
    .half_q  (half_q),
    .tick    (tick)
  );

  clkdiv_edge_gen u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .tick      (tick),
    .sclk      (sclk),
    .lead_stb  (lead_stb),
    .trail_stb (trail_stb)
  );
endmodule

// File: rtl/spi_dual_clkdiv_chk.sv
module spi_dual_clkdiv_chk #(
  parameter int CNT_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             sclk,
  input logic             lead_stb,
  input logic             trail_stb,
  input logic [CNT_W-1:0] half_q
);
  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!sclk && !lead_stb && !trail_stb));

  assert_lead_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lead_stb |-> $rose(sclk));

  assert_trail_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trail_stb |-> $fell(sclk));

  assert_rise_strobed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> lead_stb);

  assert_strobes_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lead_stb, trail_stb}));

  assert_ctrl_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |=> $stable(half_q));
endmodule

bind spi_dual_clkdiv spi_dual_clkdiv_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run_en    (run_en),
  .sclk      (sclk),
  .lead_stb  (lead_stb),
  .trail_stb (trail_stb),
  .half_q    (half_q)
);

// File: tb/spi_dual_clkdiv_bench.sv
module spi_dual_clkdiv_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0;
  logic [12:0] div_ctrl = '0;
  logic        sclk, lead_stb, trail_stb;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  spi_dual_clkdiv u_spi_dual_clkdiv (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .div_ctrl(div_ctrl),
    .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
  );

  // phase length from R2 / R3 / R4
  function automatic int exp_half(input logic [12:0] c);
    int m;
    if (c[12]) return int'(c[7:0]) + 1;
    m = int'(c[11:8]);
    return (m == 0) ? 1 : (1 << (m - 1));
  endfunction

  task automatic check3(input string req, input logic s, input logic l, input logic t,
                        input logic es, input logic el, input logic et);
    vectors++;
    if (s !== es || l !== el || t !== et) begin
      errors++;
      $display("FAIL %s: got sclk/lead/trail=%b%b%b expected %b%b%b at %0t",
               req, s, l, t, es, el, et, $time);
    end
  endtask

  // one transfer: load ctrl while idle, run T edges, optionally disturb ctrl mid-run
  task automatic run_trial(input logic [12:0] c, input int cycles, input bit disturb,
                           input logic [12:0] c2, input string req);
    int h;
    h = exp_half(c);
    @(negedge clk);
    run_en   = 1'b0;
    div_ctrl = c;
    @(negedge clk);
    @(negedge clk);
    check3("R5 idle", sclk, lead_stb, trail_stb, 1'b0, 1'b0, 1'b0);
    run_en = 1'b1;
    for (int t = 1; t <= cycles; t++) begin
      logic es, el, et;
      @(negedge clk);
      es = ((t / h) % 2) == 1;
      el = (t % h == 0) && es;
      et = (t % h == 0) && !es;
      check3(req, sclk, lead_stb, trail_stb, es, el, et);
      if (disturb && t == cycles / 2) div_ctrl = c2;
    end
    run_en = 1'b0;
    @(negedge clk);
    check3("R5 stop", sclk, lead_stb, trail_stb, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    #2;
    check3("R1 reset", sclk, lead_stb, trail_stb, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check3("R1 after reset", sclk, lead_stb, trail_stb, 1'b0, 1'b0, 1'b0);

    // R2 linear corners
    run_trial({1'b1, 4'hF, 8'd0},   20,  1'b0, '0, "R2 N=0");
    run_trial({1'b1, 4'h0, 8'd3},   40,  1'b0, '0, "R2 N=3");
    run_trial({1'b1, 4'h7, 8'd255}, 600, 1'b0, '0, "R2 N=255");
    // R3 power corners, M=0 same as M=1
    run_trial({1'b0, 4'd0, 8'hAA},  12,  1'b0, '0, "R3 M=0");
    run_trial({1'b0, 4'd1, 8'h55},  12,  1'b0, '0, "R3 M=1");
    run_trial({1'b0, 4'd5, 8'h00},  80,  1'b0, '0, "R3 M=5");
    run_trial({1'b0, 4'd15, 8'hFF}, 16390, 1'b0, '0, "R8 M=15 first rise");
    // R4 unselected field ignored
    run_trial({1'b1, 4'd9, 8'd2},   30,  1'b0, '0, "R4 linear ignores power field");
    run_trial({1'b0, 4'd3, 8'd200}, 30,  1'b0, '0, "R4 power ignores linear field");
    // R6 ctrl change during transfer has no effect
    run_trial({1'b1, 4'd0, 8'd4},   60,  1'b1, {1'b0, 4'd1, 8'd0}, "R6 linear frozen");
    run_trial({1'b0, 4'd4, 8'd0},   60,  1'b1, {1'b1, 4'd0, 8'd9}, "R6 power frozen");

    // random mix, R7 and R8 over varied phases
    for (int i = 0; i < 40; i++) begin
      logic [12:0] c, c2;
      int h;
      c = 13'($urandom);
      if (!c[12]) c[11:8] = 4'($urandom_range(0, 7));
      else        c[7:0]  = 8'($urandom_range(0, 40));
      c2 = 13'($urandom);
      h  = exp_half(c);
      run_trial(c, 4 * h + 3, i[0], c2, "R7 R8 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule